// File: doc/BRIEF.md
# Cluster Phased Clock-Enable Generator

This block runs on the fast clock of a cluster's shared cache and hands out one clock-enable pulse per cache cycle to the cores of a four-core cluster. A small slot counter divides the cache clock into slots. In the low-voltage mode every core owns one slot per core period, so the cores tick at a quarter of the cache rate, each a quarter period after the previous one. In the boost mode at most two cores stay on. The first of them takes the even slots and the second takes the odd slots, so each one ticks at half the cache rate.

The cache reads the current slot number, which core owns the slot and a busy flag, and uses them to time-multiplex its ports. The mode select and the per-core request mask are captured together only on the last slot of a round, so a new setting starts cleanly at slot 0. After reset the block waits one full round with every enable low, and then issues the first pulse.

Top module: `cluster_phase_clk`

## Requirements
- R1: `slotNum` is 0 while reset is held and after reset. It then rises by one on every cache clock edge and wraps from CORES-1 to 0.
- R2: For the first CORES cycles after reset is released (slots 0 to CORES-1), every `coreEn` bit is low and `slotBusy` is low. The first pulse can come only in the next slot 0.
- R3: With `modeSel`=0 (low-voltage mode) captured, `coreEn[i]` is high exactly in the cycles where `slotNum`==i and bit i of the captured mask is 1.
- R4: A core whose bit is 0 in the captured mask never receives a pulse. A slot with no pulsing core reports `slotBusy`=0 and `slotOwner`=0.
- R5: With `modeSel`=1 (boost mode) captured, the lowest-indexed requesting core pulses in every even slot (`slotNum` bit 0 = 0).
- R6: In boost mode the second-lowest requesting core pulses in every odd slot. If only one core requests, the odd slots are idle.
- R7: In boost mode, requesting cores beyond the lowest two never pulse.
- R8: `modeSel` and `reqMask` are sampled only at the clock edge where `slotNum`==CORES-1. Values held at any other edge have no effect.
- R9: At most one `coreEn` bit is high in any cycle. `slotBusy` is high exactly when one is high, and `slotOwner` then gives its index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cache clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 1 | 0 = quarter-rate low-voltage mode, 1 = half-rate boost mode |
| reqMask | input | CORES | Per-core run request, bit i for core i |
| coreEn | output | CORES | Per-core clock-enable pulse |
| slotNum | output | SLOT_W | Current cache slot |
| slotOwner | output | SLOT_W | Index of the core owning this slot |
| slotBusy | output | 1 | The current slot has an owner |

## Verification
The bench builds the block with the default CORES=4. At that size it walks all four quarter slots and both slot parities in each mode. It also reaches the case of three or more requesters in boost mode, where cores beyond the first two must stay silent. Inputs are changed partway through a round to show that only the value held at the last slot is taken, and a reset in the middle of a run brings back the quiet warm-up round.

// File: rtl/phase_clk_pkg.sv
package phase_clk_pkg;

  typedef enum logic {
    MODE_NTC   = 1'b0,
    MODE_BOOST = 1'b1
  } clkMode_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic live;      // warm-up round is over
    logic boost;     // captured mode is boost
    logic oddSlot;   // current slot has odd parity
    logic lastSlot;  // current slot is the final one of the round
  } phaseStrb_t;

endpackage

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import phase_clk_pkg::*;
#(
  parameter int CORES  = 4,
  parameter int SLOT_W = $clog2(CORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic [CORES-1:0]  reqMask,
  output logic [SLOT_W-1:0] slotNum,
  output logic [CORES-1:0]  maskLive,
  output phaseStrb_t        strb
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CORES - 1);

  logic [SLOT_W-1:0] slotQ;
  logic              warmQ;
  clkMode_e          modeQ;
  logic [CORES-1:0]  maskQ;
  logic              atLast;

  assign atLast = (slotQ == LAST_SLOT);

  // slot counter: one step per cache clock
  always_ff @(posedge clk) begin
    if (rst) begin
      slotQ <= '0;
    end else if (atLast) begin
      slotQ <= '0;
    end else begin
      slotQ <= slotQ + 1'b1;
    end
  end

  // warm-up flag and configuration capture at the round boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      warmQ <= 1'b0;
      modeQ <= MODE_NTC;
      maskQ <= '0;
    end else if (atLast) begin
      warmQ <= 1'b1;
      modeQ <= clkMode_e'(modeSel);
      maskQ <= reqMask;
    end
  end

  always_comb begin
    strb.live     = warmQ;
    strb.boost    = (modeQ == MODE_BOOST);
    strb.oddSlot  = slotQ[0];
    strb.lastSlot = atLast;
  end

  assign slotNum  = slotQ;
  assign maskLive = maskQ;

endmodule

// File: rtl/phase_dp.sv
module phase_dp
  import phase_clk_pkg::*;
#(
  parameter int CORES  = 4,
  parameter int SLOT_W = $clog2(CORES)
) (
  input  phaseStrb_t        strb,
  input  logic [SLOT_W-1:0] slotNum,
  input  logic [CORES-1:0]  maskLive,
  output logic [CORES-1:0]  coreEn,
  output logic [SLOT_W-1:0] slotOwner,
  output logic              slotBusy
);

  logic [CORES-1:0] ntcHit;
  logic [CORES-1:0] firstOh;
  logic [CORES-1:0] restMask;
  logic [CORES-1:0] secondOh;
  logic [CORES-1:0] boostHit;

  // quarter-phase decode: core i owns slot i
  for (genvar g = 0; g < CORES; g++) begin : g_ntc
    assign ntcHit[g] = maskLive[g] && (slotNum == SLOT_W'(g));
  end

  // boost pairing: isolate the two lowest requesters
  assign firstOh  = maskLive & (~maskLive + 1'b1);
  assign restMask = maskLive & ~firstOh;
  assign secondOh = restMask & (~restMask + 1'b1);
  assign boostHit = strb.oddSlot ? secondOh : firstOh;

  always_comb begin
    if (!strb.live) begin
      coreEn = '0;
    end else if (strb.boost) begin
      coreEn = boostHit;
    end else begin
      coreEn = ntcHit;
    end
  end

  // owner encoder
  always_comb begin
    slotOwner = '0;
    for (int i = 0; i < CORES; i++) begin
      if (coreEn[i]) slotOwner = SLOT_W'(i);
    end
  end

  assign slotBusy = |coreEn;

endmodule

// File: rtl/cluster_phase_clk.sv
module cluster_phase_clk
  import phase_clk_pkg::*;
#(
  parameter int   CORES  = 4,
  localparam int  SLOT_W = $clog2(CORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic [CORES-1:0]  reqMask,
  output logic [CORES-1:0]  coreEn,
  output logic [SLOT_W-1:0] slotNum,
  output logic [SLOT_W-1:0] slotOwner,
  output logic              slotBusy
);

  phaseStrb_t       strb;
  logic [CORES-1:0] maskLive;

  phase_ctrl #(.CORES(CORES), .SLOT_W(SLOT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .modeSel  (modeSel),
    .reqMask  (reqMask),
    .slotNum  (slotNum),
    .maskLive (maskLive),
    .strb     (strb)
  );

  phase_dp #(.CORES(CORES), .SLOT_W(SLOT_W)) u_dp (
    .strb      (strb),
    .slotNum   (slotNum),
    .maskLive  (maskLive),
    .coreEn    (coreEn),
    .slotOwner (slotOwner),
    .slotBusy  (slotBusy)
  );

endmodule

// File: rtl/cluster_phase_clk_chk.sv
module cluster_phase_clk_chk #(
  parameter int CORES  = 4,
  parameter int SLOT_W = $clog2(CORES)
) (
  input logic              clk,
  input logic              rst,
  input logic              modeSel,
  input logic [CORES-1:0]  reqMask,
  input logic [CORES-1:0]  coreEn,
  input logic [SLOT_W-1:0] slotNum,
  input logic [SLOT_W-1:0] slotOwner,
  input logic              slotBusy
);

  localparam int CW = $clog2(CORES + 1);

  logic [CW-1:0]    sinceRst;
  logic             chkMode;
  logic [CORES-1:0] chkMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
      chkMode  <= 1'b0;
      chkMask  <= '0;
    end else begin
      if (sinceRst < CW'(CORES)) sinceRst <= sinceRst + 1'b1;
      if (slotNum == SLOT_W'(CORES - 1)) begin
        chkMode <= modeSel;
        chkMask <= reqMask;
      end
    end
  end

  assert_slot_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> slotNum == SLOT_W'($past(slotNum) + 1'b1));

  assert_quiet_warmup_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < CW'(CORES)) |-> (coreEn == '0 && !slotBusy));

  assert_ntc_stagger_R3: assert property (@(posedge clk) disable iff (rst)
    (!chkMode && slotBusy) |-> slotOwner == slotNum);

  assert_no_unrequested_R4: assert property (@(posedge clk) disable iff (rst)
    (coreEn & ~chkMask) == '0);

  assert_single_owner_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(coreEn));

  assert_owner_pulses_R9: assert property (@(posedge clk) disable iff (rst)
    slotBusy |-> coreEn[slotOwner]);

endmodule

bind cluster_phase_clk cluster_phase_clk_chk #(.CORES(CORES), .SLOT_W(SLOT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .modeSel   (modeSel),
  .reqMask   (reqMask),
  .coreEn    (coreEn),
  .slotNum   (slotNum),
  .slotOwner (slotOwner),
  .slotBusy  (slotBusy)
);

// File: tb/cluster_phase_clk_test.sv
module cluster_phase_clk_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  typedef struct {
    logic [3:0] en;
    logic [1:0] slot;
    logic [1:0] owner;
    logic       busy;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel = 1'b0;
  logic [3:0] reqMask = '0;
  logic [3:0] coreEn;
  logic [1:0] slotNum;
  logic [1:0] slotOwner;
  logic       slotBusy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  expItem_t expQ[$];

  // bench model state
  int         mSlot = 0;
  bit         mWarm = 0;
  bit         mMode = 0;
  logic [3:0] mMask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_phase_clk uut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .reqMask(reqMask),
    .coreEn(coreEn), .slotNum(slotNum), .slotOwner(slotOwner), .slotBusy(slotBusy)
  );

  function automatic expItem_t predict(string tag);
    expItem_t it;
    int firstIdx = -1;
    int secondIdx = -1;
    it.en = '0;
    it.slot = 2'(mSlot);
    it.tag = tag;
    if (mWarm) begin
      if (!mMode) begin
        if (mMask[mSlot]) it.en[mSlot] = 1'b1;
      end else begin
        for (int i = 0; i < NC; i++) begin
          if (mMask[i]) begin
            if (firstIdx < 0) firstIdx = i;
            else if (secondIdx < 0) secondIdx = i;
          end
        end
        if (mSlot % 2 == 0 && firstIdx >= 0) it.en[firstIdx] = 1'b1;
        if (mSlot % 2 == 1 && secondIdx >= 0) it.en[secondIdx] = 1'b1;
      end
    end
    it.busy = (it.en != 0);
    it.owner = '0;
    for (int i = 0; i < NC; i++) if (it.en[i]) it.owner = 2'(i);
    return it;
  endfunction

  // driver: apply inputs, advance one edge, push the expected result
  task automatic step(input logic m, input logic [3:0] k, input string tag);
    modeSel = m;
    reqMask = k;
    @(posedge clk);
    if (mSlot == NC - 1) begin
      mWarm = 1;
      mMode = m;
      mMask = k;
    end
    mSlot = (mSlot + 1) % NC;
    #1;
    expQ.push_back(predict(tag));
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    mSlot = 0; mWarm = 0; mMode = 0; mMask = '0;
    expQ.push_back(predict("R2"));
  endtask

  task automatic round(input logic m, input logic [3:0] k, input string tag, input int n);
    for (int r = 0; r < n; r++) step(m, k, tag);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (slotNum !== e.slot) begin
        errors++;
        $display("FAIL R1 slotNum actual %0d expected %0d", slotNum, e.slot);
      end
      checks++;
      if (coreEn !== e.en) begin
        errors++;
        $display("FAIL %s coreEn actual %b expected %b (slot %0d)", e.tag, coreEn, e.en, e.slot);
      end
      checks++;
      if (slotBusy !== e.busy || slotOwner !== e.owner) begin
        errors++;
        $display("FAIL R9 owner/busy actual %0d/%b expected %0d/%b",
                 slotOwner, slotBusy, e.owner, e.busy);
      end
    end
  end

  initial begin
    // reset state, R1
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (slotNum !== 2'd0 || coreEn !== 4'b0 || slotBusy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state actual slot %0d en %b expected slot 0 en 0000", slotNum, coreEn);
    end
    doReset();
    round(1'b0, 4'b1111, "R2", 4);          // quiet warm-up round
    round(1'b0, 4'b1111, "R3", 8);          // all four staggered
    round(1'b0, 4'b1010, "R4", 8);          // cores 0 and 2 off
    round(1'b0, 4'b0000, "R4", 4);          // cores 1 and 3 off now
    round(1'b1, 4'b0110, "R5", 4);          // mask 0000 still live this round
    round(1'b1, 4'b0110, "R6", 8);          // core1 even, core2 odd
    round(1'b1, 4'b0100, "R6", 8);          // single core, odd idle
    round(1'b1, 4'b1111, "R7", 8);          // only cores 0 and 1
    round(1'b1, 4'b0000, "R4", 8);          // nothing requested
    // R8: inputs wobble except at the capture edge
    for (int r = 0; r < 3; r++) begin
      step(1'b1, 4'b1000, "R8");
      step(1'b0, 4'b0001, "R8");
      step(1'b1, 4'b0011, "R8");
      step(1'b0, 4'b1101, "R8");             // captured: NTC, mask 1101
    end
    round(1'b0, 4'b1101, "R3", 4);
    // reset in mid-run restores quiet round
    step(1'b1, 4'b0011, "R8");
    step(1'b1, 4'b0011, "R8");
    doReset();
    round(1'b1, 4'b0011, "R2", 4);
    round(1'b1, 4'b0011, "R5", 8);
    @(negedge clk);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule